// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small register interface for a system controller. A prescaler turns the system clock into a slow tick. On every tick the down-counter loses one count. Software keeps the system alive by writing the reload register, which puts the counter back to the programmed initial value. When the counter runs out, the block does not reset the system at once. The first expiry only raises a status flag and starts the count again. If the counter runs out a second time and that flag has not been acknowledged, the block raises a second-timeout flag and issues a one-cycle system reset request.

An external input can hold off the reset. While it is high, a second expiry still records its status, but no request goes out. The status flags clear when a 1 is written to them. Accesses are 16 bits wide, with a word index and two byte enables. Read data comes from a register and is valid one cycle after the word index is presented. The parameter `WIDE` selects between two layouts. With `WIDE=1` the initial-value field is 10 bits and sits in its own word. With `WIDE=0` it is 6 bits and sits in the upper byte of word 0.

Top module: `wdog_two_stage`

## Requirements
- R1: After a synchronous reset the following hold: the halt bit (word 4, bit 11) is 1, so word 4 reads 0x0800. The initial value is 50 ticks, or 30 when `SEC_TICK=1`. The counter holds that same value. All status bits are 0 and `sys_reset_req` is low.
- R2: A tick happens every `CYC_PER_TENTH*6` clocks, or every `CYC_PER_TENTH*10` clocks when `SEC_TICK=1`. When not halted, the counter falls by exactly one per tick. Word 0 returns the live count in its low 10 bits (`WIDE=1`) or its low 6 bits (`WIDE=0`).
- R3: When bit 11 of word 4 is 1, the counter does not change except by a reload write. Writing 0 to that bit (with byte enable 1 set) lets it count.
- R4: With `WIDE=1`, the initial value is the low 10 bits of word 9, and the upper 6 bits are plain storage. With `WIDE=0`, it is the low 6 bits of the upper byte of word 0, and the top 2 bits of that byte are plain storage. Only enabled bytes are written, and every stored bit reads back.
- R5: A write that would leave the initial-value field at 0, 1, 2 or 3 stores 4 in that field instead.
- R6: Any write that reaches the reload register loads the counter with the stored initial value. This means any byte of word 0 with `WIDE=1`, or byte 0 of word 0 with `WIDE=0`. A reload wins over a tick in the same cycle, and it cancels any expiry in that cycle.
- R7: An expiry is a tick that arrives while the counter is 0 and the timer is not halted. When the first-timeout flag (word 2, bit 3) is clear, an expiry sets that flag, reloads the counter and requests no reset.
- R8: An expiry while word 2 bit 3 is set reloads the counter, which keeps counting. It also sets the second-timeout flag (word 3, bit 1). If `reset_block` is low, it also sets the reset-issued flag (word 3, bit 2) and drives `sys_reset_req` high for exactly one clock.
- R9: While `reset_block` is high, a second expiry sets word 3 bit 1 only. `sys_reset_req` stays low and word 3 bit 2 is not set.
- R10: Writing 1 to a status bit clears it (word 2 bit 3, word 3 bits 1 and 2, byte enable 0 set). Writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R11: `rdata` is registered. It shows the register selected by `waddr` as it stood before the clock edge that captures it. Word 5 is a 16-bit general control register with byte enables. Unassigned words read 0.
- R12: Clearing word 2 bit 3 and then reloading restores the full two-pass sequence. The next expiry counts as a first expiry again and requests no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| waddr | input | 4 | Word index (byte offset divided by two) |
| be | input | 2 | Byte enables for the write |
| wdata | input | 16 | Write data |
| reset_block | input | 1 | High keeps a second expiry from issuing a reset request |
| rdata | output | 16 | Registered read data for `waddr` |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count, a lost reload or a tick in the wrong place shows up in the word-0 read one cycle after the state goes wrong. The bench compares every cycle, so the disagreement is caught within one clock of the first bad tick. A wrong stage decision shows up at the next expiry, at the latest one full pass of the counter later. It appears either as a status flag in the wrong state or as a reset pulse where none belongs, or missing where one is due. A status bit that fails to clear, or clears when it should not, is visible in the next status read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W  = 16;
  localparam int BE_W    = DATA_W / 8;
  localparam int WADDR_W = 4;

  // word index map; word 0 and the bit positions are decoded by software
  typedef enum logic [WADDR_W-1:0] {
    WA_RLD  = 4'h0,
    WA_STS1 = 4'h2,
    WA_STS2 = 4'h3,
    WA_CTL1 = 4'h4,
    WA_CTL2 = 4'h5,
    WA_INIT = 4'h9
  } wdog_word_e;

  localparam int FIRST_BIT  = 3;   // word 2
  localparam int SECOND_BIT = 1;   // word 3
  localparam int NOTE_BIT   = 2;   // word 3
  localparam int HALT_BIT   = 11;  // word 4
  localparam int MIN_INIT   = 4;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned CYC_PER_TENTH = 25_000_000,
  parameter bit          SEC_TICK      = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned TICK_CYC = CYC_PER_TENTH * (SEC_TICK ? 10 : 6);
  localparam int          PW       = $clog2(TICK_CYC + 1);

  logic [PW-1:0] pc;

  assign tick = (pc == PW'(TICK_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + PW'(1);
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int          CW       = 10,
  parameter int unsigned INIT_RST = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          halt,
  input  logic          rld_wr,
  input  logic [CW-1:0] init_fld,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  // a reload write cancels an expiry that would land in the same cycle
  assign expire = tick && !halt && !rld_wr && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= CW'(INIT_RST);
    else if (rld_wr)        cnt <= init_fld;
    else if (tick && !halt) cnt <= (cnt == '0) ? init_fld : cnt - CW'(1);
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter bit          WIDE     = 1'b1,
  parameter int unsigned INIT_RST = 50,
  localparam int         CW       = WIDE ? 10 : 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [BE_W-1:0]    be,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               reset_block,
  input  logic               expire,
  input  logic [CW-1:0]      cnt,
  output logic               rld_wr,
  output logic [CW-1:0]      init_fld,
  output logic               halt,
  output logic               first_exp,
  output logic [DATA_W-1:0]  rdata,
  output logic               sys_reset_req
);
  logic              second_exp, reset_note;
  logic [DATA_W-1:0] ctl2_q;
  logic [DATA_W-1:0] rd_word0, rd_init, rd_nxt;
  logic              wr_sts1, wr_sts2, wr_ctl1, wr_ctl2, req;

  assign wr_sts1 = wr_en && (waddr == WA_STS1) && be[0];
  assign wr_sts2 = wr_en && (waddr == WA_STS2) && be[0];
  assign wr_ctl1 = wr_en && (waddr == WA_CTL1) && be[1];
  assign wr_ctl2 = wr_en && (waddr == WA_CTL2);

  generate
    if (WIDE) begin : g_wide
      logic [15:0] init_q, merged;
      always_comb begin
        merged[15:8] = be[1] ? wdata[15:8] : init_q[15:8];
        merged[7:0]  = be[0] ? wdata[7:0]  : init_q[7:0];
      end
      always_ff @(posedge clk) begin
        if (rst) init_q <= 16'(INIT_RST);
        else if (wr_en && (waddr == WA_INIT) && (|be))
          init_q <= {merged[15:10],
                     (merged[9:0] < 10'(MIN_INIT)) ? 10'(MIN_INIT) : merged[9:0]};
      end
      assign rld_wr   = wr_en && (waddr == WA_RLD) && (|be);
      assign init_fld = init_q[CW-1:0];
      assign rd_word0 = {6'b0, cnt};
      assign rd_init  = init_q;
    end else begin : g_narrow
      logic [7:0] init_q;
      always_ff @(posedge clk) begin
        if (rst) init_q <= 8'(INIT_RST);
        else if (wr_en && (waddr == WA_RLD) && be[1])
          init_q <= {wdata[15:14],
                     (wdata[13:8] < 6'(MIN_INIT)) ? 6'(MIN_INIT) : wdata[13:8]};
      end
      assign rld_wr   = wr_en && (waddr == WA_RLD) && be[0];
      assign init_fld = init_q[CW-1:0];
      assign rd_word0 = {init_q, 2'b0, cnt};
      assign rd_init  = '0;
    end
  endgenerate

  assign req = expire && first_exp && !reset_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_exp     <= 1'b0;
      second_exp    <= 1'b0;
      reset_note    <= 1'b0;
      halt          <= 1'b1;
      ctl2_q        <= '0;
      sys_reset_req <= 1'b0;
    end else begin
      first_exp     <= (expire && !first_exp) ||
                       (first_exp && !(wr_sts1 && wdata[FIRST_BIT]));
      second_exp    <= (expire && first_exp) ||
                       (second_exp && !(wr_sts2 && wdata[SECOND_BIT]));
      reset_note    <= req || (reset_note && !(wr_sts2 && wdata[NOTE_BIT]));
      sys_reset_req <= req;
      if (wr_ctl1) halt <= wdata[HALT_BIT];
      if (wr_ctl2 && be[0]) ctl2_q[7:0]  <= wdata[7:0];
      if (wr_ctl2 && be[1]) ctl2_q[15:8] <= wdata[15:8];
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (waddr)
      WA_RLD:  rd_nxt = rd_word0;
      WA_STS1: rd_nxt[FIRST_BIT] = first_exp;
      WA_STS2: begin
        rd_nxt[SECOND_BIT] = second_exp;
        rd_nxt[NOTE_BIT]   = reset_note;
      end
      WA_CTL1: rd_nxt[HALT_BIT] = halt;
      WA_CTL2: rd_nxt = ctl2_q;
      WA_INIT: rd_nxt = rd_init;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter bit          WIDE          = 1'b1,
  parameter int unsigned CYC_PER_TENTH = 25_000_000,
  parameter bit          SEC_TICK      = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [BE_W-1:0]    be,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               reset_block,
  output logic [DATA_W-1:0]  rdata,
  output logic               sys_reset_req
);
  localparam int          CW       = WIDE ? 10 : 6;
  localparam int unsigned INIT_RST = SEC_TICK ? 30 : 50;

  logic          tick, halt, rld_wr, expire, first_exp;
  logic [CW-1:0] cnt, init_fld;

  wdog_tick_gen #(
    .CYC_PER_TENTH(CYC_PER_TENTH),
    .SEC_TICK     (SEC_TICK)
  ) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  wdog_count #(
    .CW      (CW),
    .INIT_RST(INIT_RST)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .halt    (halt),
    .rld_wr  (rld_wr),
    .init_fld(init_fld),
    .cnt     (cnt),
    .expire  (expire)
  );

  wdog_regs #(
    .WIDE    (WIDE),
    .INIT_RST(INIT_RST)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .waddr        (waddr),
    .be           (be),
    .wdata        (wdata),
    .reset_block  (reset_block),
    .expire       (expire),
    .cnt          (cnt),
    .rld_wr       (rld_wr),
    .init_fld     (init_fld),
    .halt         (halt),
    .first_exp    (first_exp),
    .rdata        (rdata),
    .sys_reset_req(sys_reset_req)
  );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
  import wdog_pkg::*;
#(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          reset_block,
  input logic          sys_reset_req,
  input logic          halt,
  input logic          rld_wr,
  input logic          expire,
  input logic          first_exp,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] init_fld
);
  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !rld_wr) |=> $stable(cnt));

  // R5
  init_floor_chk: assert property (@(posedge clk) disable iff (rst)
    init_fld >= CW'(MIN_INIT));

  // R6
  reload_load_chk: assert property (@(posedge clk) disable iff (rst)
    rld_wr |=> (cnt == $past(init_fld)));

  // R7
  first_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !first_exp) |=> (first_exp && !sys_reset_req));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> !sys_reset_req);

  // R8
  req_second_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(first_exp && expire));

  // R9
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> !$past(reset_block));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reset_block  (reset_block),
  .sys_reset_req(sys_reset_req),
  .halt         (halt),
  .rld_wr       (rld_wr),
  .expire       (expire),
  .first_exp    (first_exp),
  .cnt          (cnt),
  .init_fld     (init_fld)
);

// File: tb/wdog_two_stage_bench.sv
`timescale 1ns/1ps
module wdog_two_stage_bench;
  localparam int TICKN = 6;  // one clock per tenth, 0.6 s tick

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  waddr = 4'h0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = 16'h0;
  logic        reset_block = 1'b0;
  logic [15:0] rdata;
  logic        sys_reset_req;

  int checks = 0;
  int errors = 0;
  int n_req  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdog_two_stage #(.WIDE(1'b1), .CYC_PER_TENTH(1), .SEC_TICK(1'b0)) u_wdog_two_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr), .be(be), .wdata(wdata),
    .reset_block(reset_block), .rdata(rdata), .sys_reset_req(sys_reset_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_pc;
  int          m_cnt;
  logic [15:0] m_init, m_ctl2, m_rdata;
  bit          m_halt, m_first, m_second, m_note, m_req;

  always @(posedge clk) begin
    logic [15:0] rv, ni;
    bit tick, rld, exp_now, was_first;
    if (rst) begin
      m_pc = 0; m_cnt = 50; m_init = 16'd50; m_ctl2 = 16'h0; m_rdata = 16'h0;
      m_halt = 1; m_first = 0; m_second = 0; m_note = 0; m_req = 0;
    end else begin
      case (waddr)
        4'h0: rv = 16'(m_cnt);
        4'h2: rv = m_first ? 16'h0008 : 16'h0000;
        4'h3: rv = (m_second ? 16'h0002 : 16'h0000) | (m_note ? 16'h0004 : 16'h0000);
        4'h4: rv = m_halt ? 16'h0800 : 16'h0000;
        4'h5: rv = m_ctl2;
        4'h9: rv = m_init;
        default: rv = 16'h0;
      endcase
      tick = (m_pc == TICKN - 1);
      m_pc = tick ? 0 : m_pc + 1;
      rld = wr_en && waddr == 4'h0 && be != 2'b00;
      exp_now = tick && !m_halt && !rld && m_cnt == 0;
      was_first = m_first;
      if (rld) m_cnt = int'(m_init[9:0]);
      else if (tick && !m_halt) m_cnt = (m_cnt == 0) ? int'(m_init[9:0]) : m_cnt - 1;
      m_req = exp_now && was_first && !reset_block;
      if (exp_now && !was_first) m_first = 1;
      else if (wr_en && waddr == 4'h2 && be[0] && wdata[3]) m_first = 0;
      if (exp_now && was_first) m_second = 1;
      else if (wr_en && waddr == 4'h3 && be[0] && wdata[1]) m_second = 0;
      if (m_req) m_note = 1;
      else if (wr_en && waddr == 4'h3 && be[0] && wdata[2]) m_note = 0;
      if (wr_en && waddr == 4'h9 && be != 2'b00) begin
        ni = m_init;
        if (be[0]) ni[7:0] = wdata[7:0];
        if (be[1]) ni[15:8] = wdata[15:8];
        if (ni[9:0] < 10'd4) ni[9:0] = 10'd4;
        m_init = ni;
      end
      if (wr_en && waddr == 4'h4 && be[1]) m_halt = wdata[11];
      if (wr_en && waddr == 4'h5 && be[0]) m_ctl2[7:0] = wdata[7:0];
      if (wr_en && waddr == 4'h5 && be[1]) m_ctl2[15:8] = wdata[15:8];
      m_rdata = rv;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R11 rdata vs model", rdata, m_rdata);
      check("R8 sys_reset_req vs model", 16'(sys_reset_req), 16'(m_req));
      if (sys_reset_req) n_req++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; wdata = d; be = b;
    @(negedge clk);
    wr_en = 1'b0; be = 2'b00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    waddr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v1, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h4, v); check("R1 halt set", v, 16'h0800);
    rd(4'h9, v); check("R1 initial value", v, 16'd50);
    rd(4'h0, v); check("R1 counter", v, 16'd50);
    rd(4'h2, v); check("R1 status word 2", v, 16'h0000);
    rd(4'h3, v); check("R1 status word 3", v, 16'h0000);
    check("R1 no request", 16'(sys_reset_req), 16'h0);

    // R3 halted counter does not move
    repeat (30) @(negedge clk);
    rd(4'h0, v); check("R3 halted count", v, 16'd50);

    // R4, R5 initial value writes
    wr(4'h9, 16'hFC02, 2'b11); rd(4'h9, v); check("R5 clamp with upper bits", v, 16'hFC04);
    wr(4'h9, 16'h0007, 2'b01); rd(4'h9, v); check("R4 low byte only", v, 16'hFC07);
    wr(4'h9, 16'h0003, 2'b11); rd(4'h9, v); check("R5 clamp 3", v, 16'h0004);
    wr(4'h9, 16'h0008, 2'b11); rd(4'h9, v); check("R4 full write", v, 16'h0008);

    // R6 reload while halted
    wr(4'h0, 16'h1234, 2'b01); rd(4'h0, v); check("R6 reload", v, 16'd8);

    // R2 count one per tick
    wr(4'h4, 16'h0000, 2'b10);
    rd(4'h0, v1); repeat (4) @(negedge clk); rd(4'h0, v2);
    check("R2 one step per tick", v2, v1 - 16'd1);

    // R7 first expiry
    repeat (55) @(negedge clk);
    rd(4'h2, v); check("R7 first flag", v, 16'h0008);
    rd(4'h3, v); check("R7 no second flag", v, 16'h0000);
    check("R7 no request yet", 16'(n_req), 16'd0);

    // R8 second expiry
    repeat (45) @(negedge clk);
    rd(4'h3, v); check("R8 second and issued flags", v, 16'h0006);
    check("R8 one request pulse", 16'(n_req), 16'd1);
    rd(4'h0, v1); repeat (4) @(negedge clk); rd(4'h0, v2);
    check("R8 keeps counting", v2, v1 - 16'd1);
    wr(4'h4, 16'h0800, 2'b10);

    // R10 write one to clear
    wr(4'h3, 16'h0000, 2'b01); rd(4'h3, v); check("R10 zero keeps", v, 16'h0006);
    wr(4'h3, 16'h0002, 2'b01); rd(4'h3, v); check("R10 clear second", v, 16'h0004);
    wr(4'h3, 16'h0004, 2'b01); rd(4'h3, v); check("R10 clear issued", v, 16'h0000);
    wr(4'h2, 16'h0000, 2'b01); rd(4'h2, v); check("R10 zero keeps first", v, 16'h0008);
    wr(4'h2, 16'h0008, 2'b01); rd(4'h2, v); check("R10 clear first", v, 16'h0000);

    // R9 reset held off
    reset_block = 1'b1;
    wr(4'h0, 16'h0000, 2'b11);
    wr(4'h4, 16'h0000, 2'b10);
    repeat (115) @(negedge clk);
    wr(4'h4, 16'h0800, 2'b10);
    rd(4'h3, v); check("R9 second flag only", v, 16'h0002);
    rd(4'h2, v); check("R9 first flag", v, 16'h0008);
    check("R9 no new request", 16'(n_req), 16'd1);

    // R12 acknowledge restores two passes
    wr(4'h2, 16'h0008, 2'b01);
    wr(4'h3, 16'h0006, 2'b01);
    reset_block = 1'b0;
    wr(4'h0, 16'h0000, 2'b01);
    wr(4'h4, 16'h0000, 2'b10);
    repeat (60) @(negedge clk);
    rd(4'h2, v); check("R12 first pass", v, 16'h0008);
    wr(4'h2, 16'h0008, 2'b01);
    wr(4'h0, 16'h0000, 2'b01);
    repeat (60) @(negedge clk);
    rd(4'h2, v); check("R12 first again", v, 16'h0008);
    rd(4'h3, v); check("R12 no second", v, 16'h0000);
    check("R12 no request", 16'(n_req), 16'd1);
    wr(4'h4, 16'h0800, 2'b10);

    // R11 general control word with byte enables
    wr(4'h5, 16'hA55A, 2'b10); rd(4'h5, v); check("R11 upper byte", v, 16'hA500);
    wr(4'h5, 16'h1234, 2'b01); rd(4'h5, v); check("R11 lower byte", v, 16'hA534);
    rd(4'h7, v); check("R11 unassigned word", v, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule